// File: doc/BRIEF.md
# PWM Channel Period Timebase

This block is the timebase of one pulse-width-modulation channel. A counter advances on a selectable counter tick and repeats with a programmed period. The tick comes either from one of eleven power-of-two taps of a free-running prescaler on the peripheral clock, or from one of two linear dividers with 8-bit factors. The counter runs in one of two alignments. In edge alignment it counts up and wraps. In center alignment it counts up to the period value and back down to zero, which doubles the output period for the same settings.

Software programs the channel through a plain write port: enable, a 2-bit address and 32-bit data. Period, duty and alignment are written to shadow copies. The counter takes them up only at the end of the running period, so no partial period is ever produced. Writes to the period register are refused while either of two lock inputs is raised. The block drives a waveform output that compares the counter against the duty value, and a one-cycle pulse at each period end. The current count is also brought out.

Top module: `pwm_period_timer`

## Requirements
- R1: After reset all registers read as zero. This gives edge alignment, tap 0, both divider factors 0, period 0 and duty 0. With an active period of 0 the counter rests at 0 and produces no period-end pulse, and `wave_out`, `period_end` and `cnt_value` are all 0.
- R2: Register map, by `wr_addr`. Address 0 is configuration: bit 0 selects alignment (0 edge, 1 center) and bits 7:4 hold the clock select. Address 1 holds the divider factors: A in bits 7:0 and B in bits 15:8. Address 2 holds the period in bits 15:0. Address 3 holds the duty in bits 15:0. Data bits 31:16 written to the period register are ignored.
- R3: A clock select s in the range 0 to 10 produces one counter tick every 2^s peripheral clocks.
- R4: Clock select 11 uses divider A and clock select 12 uses divider B. A factor N in the range 1 to 255 produces one tick every N clocks. A factor of 0, or a clock select of 13 to 15, produces no ticks, and the count then holds its value with no period-end pulse.
- R5: In edge alignment with an active period P > 0 and a divide D, the counter steps 0, 1, ..., P-1 and wraps to 0. The distance between period-end pulses is P*D clocks.
- R6: In center alignment the counter steps up from 0 to P and back down to 0, taking 2*P ticks. The distance between period-end pulses is 2*P*D clocks.
- R7: A write to the period register (address 2) is dropped when `sw_lock` or `hw_lock` is high. It is accepted when both are low.
- R8: Period, duty and alignment are written to shadow copies. They become active only at a period end, or on any tick while the active period is 0. A period written mid-period therefore leaves the length of the current period unchanged.
- R9: `wave_out` is high while the count is below the active duty. For a duty value d ≤ P, the output is high for d*D clocks per period in edge alignment. In center alignment it is high for (2*d-1)*D clocks when d ≥ 1, and for 0 clocks when d = 0.
- R10: `period_end` is high for one clock after the tick that ends a period. That tick is the wrap in edge alignment and the return to 0 in center alignment. While `period_end` is high, `cnt_value` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 32 | Write data |
| sw_lock | input | 1 | Software write lock for the period register |
| hw_lock | input | 1 | Hardware write lock for the period register |
| wave_out | output | 1 | Waveform, high while the count is below the duty |
| period_end | output | 1 | One-clock pulse at each period end |
| cnt_value | output | 16 | Current counter value |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, 32-bit data, 8-bit divider factors and eleven prescaler taps. With these defaults, the deepest tap (divide by 1024) can be reached with a short period and stays within the run time. Small divider factors and periods up to 12 keep each random case to a few hundred clocks. The 4-bit select field also leaves three unused codes (13 to 15), and the bench drives one of them to show that the counter halts.

// File: rtl/pwm_timebase_pkg.sv
package pwm_timebase_pkg;
   localparam int unsigned ADR_CFG     = 0;
   localparam int unsigned ADR_DIV     = 1;
   localparam int unsigned ADR_PRD     = 2;
   localparam int unsigned ADR_DUTY    = 3;
   localparam int unsigned CFG_SEL_LSB = 4;

   typedef enum logic {
      ALIGN_EDGE   = 1'b0,
      ALIGN_CENTER = 1'b1
   } align_e;
endpackage

// File: rtl/pwm_tb_regs.sv
module pwm_tb_regs
   import pwm_timebase_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned DIV_W  = 8,
   parameter int unsigned SEL_W  = 4,
   parameter int unsigned ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              sw_lock,
   input  logic              hw_lock,
   output align_e            mode_shd,
   output logic [SEL_W-1:0]  sel,
   output logic [DIV_W-1:0]  div_a,
   output logic [DIV_W-1:0]  div_b,
   output logic [CNT_W-1:0]  prd_shd,
   output logic [CNT_W-1:0]  duty_shd
);
   logic prd_open;
   assign prd_open = !sw_lock && !hw_lock;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_shd <= ALIGN_EDGE;
         sel      <= '0;
         div_a    <= '0;
         div_b    <= '0;
         prd_shd  <= '0;
         duty_shd <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            ADDR_W'(ADR_CFG): begin
               mode_shd <= align_e'(wr_data[0]);
               sel      <= wr_data[CFG_SEL_LSB +: SEL_W];
            end
            ADDR_W'(ADR_DIV): begin
               div_a <= wr_data[0 +: DIV_W];
               div_b <= wr_data[DIV_W +: DIV_W];
            end
            ADDR_W'(ADR_PRD): begin
               if (prd_open) prd_shd <= wr_data[CNT_W-1:0];
            end
            ADDR_W'(ADR_DUTY): duty_shd <= wr_data[CNT_W-1:0];
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/pwm_tb_lindiv.sv
module pwm_tb_lindiv #(
   parameter int unsigned DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] factor,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;

   assign tick = (factor != '0) && (cnt >= factor - 1'b1);

   always_ff @(posedge clk) begin
      if (!rst_n)                    cnt <= '0;
      else if (factor == '0 || tick) cnt <= '0;
      else                           cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/pwm_tb_clksel.sv
module pwm_tb_clksel #(
   parameter int unsigned NUM_TAPS = 11,
   parameter int unsigned DIV_W    = 8,
   parameter int unsigned SEL_W    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel,
   input  logic [DIV_W-1:0] div_a,
   input  logic [DIV_W-1:0] div_b,
   output logic             tick
);
   localparam int unsigned PRE_W = NUM_TAPS - 1;
   localparam int unsigned N_DIV = 2;

   logic [PRE_W-1:0]    pre;
   logic [NUM_TAPS-1:0] tap_tick;
   logic [DIV_W-1:0]    factors [N_DIV];
   logic [N_DIV-1:0]    div_tick;

   always_ff @(posedge clk) begin
      if (!rst_n) pre <= '0;
      else        pre <= pre + 1'b1;
   end

   assign tap_tick[0] = 1'b1;
   generate
      for (genvar k = 1; k < NUM_TAPS; k++) begin : g_tap
         assign tap_tick[k] = &pre[k-1:0];
      end
   endgenerate

   assign factors[0] = div_a;
   assign factors[1] = div_b;

   generate
      for (genvar d = 0; d < N_DIV; d++) begin : g_div
         pwm_tb_lindiv #(.DIV_W(DIV_W)) u_div (
            .clk    (clk),
            .rst_n  (rst_n),
            .factor (factors[d]),
            .tick   (div_tick[d])
         );
      end
   endgenerate

   always_comb begin
      tick = 1'b0;
      if (sel < SEL_W'(NUM_TAPS))           tick = tap_tick[sel];
      else if (sel == SEL_W'(NUM_TAPS))     tick = div_tick[0];
      else if (sel == SEL_W'(NUM_TAPS + 1)) tick = div_tick[1];
   end
endmodule

// File: rtl/pwm_tb_counter.sv
module pwm_tb_counter
   import pwm_timebase_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  align_e           mode_shd,
   input  logic [CNT_W-1:0] prd_shd,
   input  logic [CNT_W-1:0] duty_shd,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] prd_act,
   output align_e           mode_act,
   output logic             period_end,
   output logic             wave
);
   logic [CNT_W-1:0] duty_act;
   logic             dir_down;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt        <= '0;
         prd_act    <= '0;
         duty_act   <= '0;
         mode_act   <= ALIGN_EDGE;
         dir_down   <= 1'b0;
         period_end <= 1'b0;
      end else begin
         period_end <= 1'b0;
         if (tick) begin
            if (prd_act == '0) begin
               cnt      <= '0;
               dir_down <= 1'b0;
               prd_act  <= prd_shd;
               duty_act <= duty_shd;
               mode_act <= mode_shd;
            end else if (mode_act == ALIGN_EDGE) begin
               if (cnt >= prd_act - 1'b1) begin
                  cnt        <= '0;
                  period_end <= 1'b1;
                  dir_down   <= 1'b0;
                  prd_act    <= prd_shd;
                  duty_act   <= duty_shd;
                  mode_act   <= mode_shd;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end else if (!dir_down) begin
               cnt <= cnt + 1'b1;
               if (cnt + 1'b1 >= prd_act) dir_down <= 1'b1;
            end else begin
               if (cnt <= CNT_W'(1)) begin
                  cnt        <= '0;
                  period_end <= 1'b1;
                  dir_down   <= 1'b0;
                  prd_act    <= prd_shd;
                  duty_act   <= duty_shd;
                  mode_act   <= mode_shd;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
         end
      end
   end

   assign wave = cnt < duty_act;
endmodule

// File: rtl/pwm_period_timer.sv
module pwm_period_timer
   import pwm_timebase_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned DIV_W    = 8,
   parameter int unsigned NUM_TAPS = 11,
   parameter int unsigned ADDR_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              sw_lock,
   input  logic              hw_lock,
   output logic              wave_out,
   output logic              period_end,
   output logic [CNT_W-1:0]  cnt_value
);
   localparam int unsigned SEL_W = $clog2(NUM_TAPS + 2);

   generate
      if (CNT_W > DATA_W)                    begin : g_err_cnt  $error("CNT_W exceeds DATA_W"); end
      if (2 * DIV_W > DATA_W)                begin : g_err_div  $error("divider fields exceed DATA_W"); end
      if (CFG_SEL_LSB + SEL_W > DATA_W)      begin : g_err_sel  $error("select field exceeds DATA_W"); end
      if (NUM_TAPS < 2)                      begin : g_err_tap  $error("NUM_TAPS must be at least 2"); end
      if (ADDR_W < 2)                        begin : g_err_adr  $error("ADDR_W must cover four registers"); end
   endgenerate

   align_e           mode_shd;
   align_e           mode_act;
   logic [SEL_W-1:0] sel;
   logic [DIV_W-1:0] div_a;
   logic [DIV_W-1:0] div_b;
   logic [CNT_W-1:0] prd_shd;
   logic [CNT_W-1:0] duty_shd;
   logic [CNT_W-1:0] prd_act;
   logic             tick;

   pwm_tb_regs #(
      .DATA_W(DATA_W), .CNT_W(CNT_W), .DIV_W(DIV_W), .SEL_W(SEL_W), .ADDR_W(ADDR_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .sw_lock  (sw_lock),
      .hw_lock  (hw_lock),
      .mode_shd (mode_shd),
      .sel      (sel),
      .div_a    (div_a),
      .div_b    (div_b),
      .prd_shd  (prd_shd),
      .duty_shd (duty_shd)
   );

   pwm_tb_clksel #(
      .NUM_TAPS(NUM_TAPS), .DIV_W(DIV_W), .SEL_W(SEL_W)
   ) u_clksel (
      .clk   (clk),
      .rst_n (rst_n),
      .sel   (sel),
      .div_a (div_a),
      .div_b (div_b),
      .tick  (tick)
   );

   pwm_tb_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .mode_shd   (mode_shd),
      .prd_shd    (prd_shd),
      .duty_shd   (duty_shd),
      .cnt        (cnt_value),
      .prd_act    (prd_act),
      .mode_act   (mode_act),
      .period_end (period_end),
      .wave       (wave_out)
   );
endmodule

// File: rtl/pwm_period_timer_chk.sv
module pwm_period_timer_chk
   import pwm_timebase_pkg::*;
#(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned ADDR_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              sw_lock,
   input logic              hw_lock,
   input logic [CNT_W-1:0]  cnt_value,
   input logic              period_end,
   input logic [CNT_W-1:0]  prd_act,
   input logic              center_act,
   input logic [CNT_W-1:0]  prd_shd,
   input logic              tick
);
   a_r5_edge_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (!center_act && prd_act != '0) |-> cnt_value < prd_act);

   a_r6_center_bound: assert property (@(posedge clk) disable iff (!rst_n)
      center_act |-> cnt_value <= prd_act);

   a_r4_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt_value));

   a_r10_end_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      period_end |-> cnt_value == '0);

   a_r7_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(ADR_PRD) && (sw_lock || hw_lock)) |=> $stable(prd_shd));

   a_r8_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && prd_act != '0) |=> (cnt_value == $past(cnt_value) + 1'b1 ||
                                   cnt_value == $past(cnt_value) - 1'b1 ||
                                   cnt_value == '0));
endmodule

bind pwm_period_timer pwm_period_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_addr    (wr_addr),
   .sw_lock    (sw_lock),
   .hw_lock    (hw_lock),
   .cnt_value  (cnt_value),
   .period_end (period_end),
   .prd_act    (prd_act),
   .center_act (mode_act),
   .prd_shd    (prd_shd),
   .tick       (tick)
);

// File: tb/sim_pwm_period_timer.sv
module sim_pwm_period_timer;
   localparam int LIMIT = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        sw_lock = 1'b0;
   logic        hw_lock = 1'b0;
   logic        wave_out;
   logic        period_end;
   logic [15:0] cnt_value;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   always #10 clk = ~clk;

   pwm_period_timer u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .sw_lock(sw_lock), .hw_lock(hw_lock), .wave_out(wave_out),
      .period_end(period_end), .cnt_value(cnt_value)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 150000) begin
         errors = errors + 1;
         $display("FAIL watchdog: all requirements, actual cycle %0d expected finish earlier", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   function automatic int exp_div(int sel, int fa, int fb);
      if (sel <= 10) return 1 << sel;
      if (sel == 11) return fa;
      if (sel == 12) return fb;
      return 0;
   endfunction

   function automatic int exp_len(int center, int p, int d);
      return (center != 0) ? 2 * p * d : p * d;
   endfunction

   function automatic int exp_hi(int center, int duty, int d);
      if (center == 0) return duty * d;
      if (duty == 0) return 0;
      return (2 * duty - 1) * d;
   endfunction

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic wr(int addr, logic [31:0] data);
      @(posedge clk); #1;
      wr_en = 1'b1; wr_addr = 2'(addr); wr_data = data;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic wait_pe(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!period_end && n < LIMIT);
   endtask

   task automatic measure(output int len, output int hi);
      len = 0; hi = 0;
      do begin
         len++;
         if (wave_out) hi++;
         @(negedge clk);
      end while (!period_end && len < LIMIT);
   endtask

   task automatic configure(int center, int sel, int fa, int fb, int p, int duty);
      wr(1, 32'((fb << 8) | fa));
      wr(3, 32'(duty));
      wr(2, 32'(p));
      wr(0, 32'((sel << 4) | center));
   endtask

   task automatic run_case(string tag, int center, int sel, int fa, int fb, int p, int duty);
      int n, len, hi, d;
      configure(center, sel, fa, fb, p, duty);
      wait_pe(n);
      wait_pe(n);
      measure(len, hi);
      d = exp_div(sel, fa, fb);
      chk({tag, " period"}, len, exp_len(center, p, d));
      chk({tag, " wave high"}, hi, exp_hi(center, duty, d));
   endtask

   initial begin
      int n, len, hi, t0, c0, pes;
      void'($urandom(32'd77031));
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      repeat (5) @(negedge clk);
      // R1: idle after reset
      chk("R1 wave_out at reset", int'(wave_out), 0);
      chk("R1 period_end at reset", int'(period_end), 0);
      chk("R1 cnt_value at reset", int'(cnt_value), 0);

      // R5 R9: edge alignment, tap 0
      run_case("R5 R9 edge tap0", 0, 0, 0, 0, 5, 2);
      // R6 R9: center alignment, tap 2
      run_case("R6 R9 center tap2", 1, 2, 0, 0, 4, 3);
      // R3: deepest tap
      run_case("R3 tap10", 0, 10, 0, 0, 2, 1);
      // R4: divider A and B
      run_case("R4 divA center", 1, 11, 7, 1, 3, 3);
      run_case("R4 divB edge", 0, 12, 1, 5, 6, 0);
      // R9: duty equal to period, edge gives full high
      run_case("R9 full duty", 0, 1, 0, 0, 4, 4);

      // R10: pulse one cycle wide and count 0
      wait_pe(n);
      chk("R10 count at period end", int'(cnt_value), 0);
      @(negedge clk);
      chk("R10 pulse width", int'(period_end), 0);

      // R2: upper bits of period ignored
      configure(0, 0, 0, 0, 4, 1);
      wr(2, 32'hABCD_0006);
      wait_pe(n); wait_pe(n);
      measure(len, hi);
      chk("R2 period upper bits ignored", len, 6);

      // R7: locks
      sw_lock = 1'b1;
      wr(2, 32'd9);
      sw_lock = 1'b0;
      hw_lock = 1'b1;
      wr(2, 32'd11);
      hw_lock = 1'b0;
      wait_pe(n); wait_pe(n);
      measure(len, hi);
      chk("R7 locked period write dropped", len, 6);
      wr(2, 32'd9);
      wait_pe(n); wait_pe(n);
      measure(len, hi);
      chk("R7 unlocked period write taken", len, 9);

      // R8: mid-period write does not alter current period
      wait_pe(n);
      t0 = cyc;
      wr(2, 32'd3);
      wait_pe(n);
      chk("R8 current period kept", cyc - t0, 9);
      measure(len, hi);
      chk("R8 new period after end", len, 3);

      // R4: divider factor 0 halts the counter
      configure(0, 11, 0, 0, 8, 2);
      @(negedge clk);
      c0 = int'(cnt_value);
      pes = 0;
      repeat (300) begin
         @(negedge clk);
         if (period_end) pes++;
      end
      chk("R4 factor 0 holds count", int'(cnt_value), c0);
      chk("R4 factor 0 no period end", pes, 0);

      // R4: unused select code halts the counter
      wr(1, 32'h0303);
      wr(0, 32'(13 << 4));
      @(negedge clk);
      c0 = int'(cnt_value);
      pes = 0;
      repeat (300) begin
         @(negedge clk);
         if (period_end) pes++;
      end
      chk("R4 select 13 holds count", int'(cnt_value), c0);
      chk("R4 select 13 no period end", pes, 0);

      // R5 R6 R9 random mix
      for (int i = 0; i < 8; i++) begin
         int center, kind, sel, fa, fb, p, duty;
         center = int'($urandom_range(0, 1));
         kind   = int'($urandom_range(0, 2));
         fa     = int'($urandom_range(1, 5));
         fb     = int'($urandom_range(1, 5));
         sel    = (kind == 0) ? int'($urandom_range(0, 3)) : 10 + kind;
         p      = int'($urandom_range(1, 12));
         duty   = int'($urandom_range(0, p));
         run_case(center != 0 ? "R6 R9 random" : "R5 R9 random", center, sel, fa, fb, p, duty);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule